// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host-side master for a 12-bit converter that has a three-wire serial link: an active-low select, a data clock driven by the host and one data line back to the host. A one-cycle start request pulls select low. The block then produces a burst of data-clock pulses at a rate set by a runtime divider of the system clock. It samples the data line on each rising edge of the data clock, because the converter changes that line on falling edges. The first rising edge of a frame sees an undriven line. The second sees a zero filler bit. The block discards both and shifts in the 12 result bits from most significant to least significant.

When `MIRROR_CHECK` is set, the block keeps clocking for eleven more edges. Over those edges the converter repeats the word least significant first, starting at bit 1, since bit 0 belongs to both copies. The block compares that repeat with the first copy. After the last edge the data clock goes back low and select is raised. In the same cycle the word is loaded into the result register, the compare outcome is loaded into the mismatch flag, and a one-cycle valid pulse is given. Select then stays high for one full data-clock period before a new start is accepted. A start that arrives while the block is busy is dropped.

Top module: `adcrd_master`

## Requirements
- R1: Out of reset, select (`cs_n`) is high, `sclk` is low, and `busy`, `valid` and `mismatch` are low.
- R2: While select is low, each high phase and each low phase of `sclk` lasts exactly `div_half`+1 system clock cycles. This includes the low phase right after select falls and the low phase right before select rises.
- R3: The first two rising `sclk` edges of a frame are not captured. The value on `sdata_in` at rising edges 3 to 14 becomes `result` bits 11 down to 0, in that order.
- R4: A frame holds exactly 14 rising `sclk` edges when `MIRROR_CHECK`=0 and exactly 25 when `MIRROR_CHECK`=1. Select rises only after `sclk` has returned low.
- R5: When `MIRROR_CHECK`=1, rising edges 15 to 25 carry word bits 1 up to 11. `mismatch` is set with the valid pulse if any of these bits differs from the same bit of the first copy, and is cleared otherwise. When `MIRROR_CHECK`=0, `mismatch` stays low.
- R6: `valid` is high for exactly one cycle, and only in the cycle in which select rises. `result` and `mismatch` take their new values in that same cycle.
- R7: `busy` is high from the cycle after an accepted start until the end of the cycle 2*(`div_half`+1)-1 after the valid cycle. Counting the valid cycle, that is 2*(`div_half`+1) cycles in all.
- R8: `sclk` never goes high while select is high.
- R9: A start pulse that arrives while `busy` is high has no effect. The frame in progress keeps its edge count, and no second frame follows it.
- R10: `result` and `mismatch` hold their values in every cycle without a valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to read the converter |
| div_half | input | DIV_W | Half period of the data clock in system cycles, minus one |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Data clock to the converter |
| result | output | DATA_W | Last captured word |
| valid | output | 1 | One-cycle pulse when `result` is updated |
| mismatch | output | 1 | The repeated copy disagreed with the first copy |
| busy | output | 1 | A frame or the select-high recovery time is in progress |

## Verification
The bound checker covers the properties that can be judged in every cycle without knowing the data. These are: no clock while select is high, the valid pulse coinciding with the rise of select and lasting one cycle, the result and flag holding between pulses, and select staying high while idle. Edge counts, phase lengths, bit order, the handling of the lead-in bits, the mirror compare and the recovery time all depend on the converter's replies. Only the bench scenarios show those. In them a converter model answers on falling edges, and one variant deliberately corrupts bits of the repeated copy.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_HOLD = 2'd2
   } adcrd_state_e;

   // enable edge plus filler bit ahead of the word
   localparam int LEAD_EDGES = 2;

   function automatic int frame_edges(input int width, input bit mirror);
      return LEAD_EDGES + width + (mirror ? width - 1 : 0);
   endfunction

endpackage

// File: rtl/adcrd_tick.sv
module adcrd_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_half,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart || cnt_q == '0)
         cnt_q <= div_half;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick = !restart && (cnt_q == '0);

endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture #(
   parameter int DATA_W       = 12,
   parameter bit MIRROR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [DATA_W-1:0] word,
   output logic              mism
);

   localparam int CAP_W = MIRROR_CHECK ? (2 * DATA_W - 1) : DATA_W;

   logic [CAP_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (clear)
         sh_q <= '0;
      else if (shift_en)
         sh_q <= {sh_q[CAP_W-2:0], bit_in};
   end

   generate
      if (MIRROR_CHECK) begin : g_mirror
         // sh_q[0] holds the last repeated bit (bit DATA_W-1), sh_q[DATA_W-2] holds bit 1
         logic [DATA_W-2:0] diff;
         assign word = sh_q[CAP_W-1 -: DATA_W];
         for (genvar i = 1; i < DATA_W; i++) begin : g_cmp
            assign diff[i-1] = word[i] ^ sh_q[DATA_W-1-i];
         end
         assign mism = |diff;
      end else begin : g_plain
         assign word = sh_q;
         assign mism = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adcrd_master.sv
module adcrd_master
   import adcrd_pkg::*;
#(
   parameter int DATA_W       = 12,
   parameter int DIV_W        = 8,
   parameter bit MIRROR_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              sdata_in,
   output logic              cs_n,
   output logic              sclk,
   output logic [DATA_W-1:0] result,
   output logic              valid,
   output logic              mismatch,
   output logic              busy
);

   localparam int N_EDGES = frame_edges(DATA_W, MIRROR_CHECK);
   localparam int EDGE_W  = $clog2(N_EDGES + 1);

   initial begin
      if (DATA_W < 2)  $error("DATA_W must be at least 2");
      if (DIV_W < 1)   $error("DIV_W must be at least 1");
   end

   adcrd_state_e      st_q;
   logic [EDGE_W-1:0] edges_q;
   logic              hold_q;
   logic              tick;
   logic              last_edge;
   logic              cap_clear;
   logic              cap_shift;
   logic [DATA_W-1:0] cap_word;
   logic              cap_mism;

   assign last_edge = (edges_q == EDGE_W'(N_EDGES));
   assign cap_clear = (st_q == ST_IDLE) && start;
   assign cap_shift = (st_q == ST_RUN) && tick && !sclk && !last_edge &&
                      (edges_q >= EDGE_W'(LEAD_EDGES));

   adcrd_tick #(.DIV_W(DIV_W)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (st_q == ST_IDLE),
      .div_half (div_half),
      .tick     (tick)
   );

   adcrd_capture #(.DATA_W(DATA_W), .MIRROR_CHECK(MIRROR_CHECK)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cap_clear),
      .shift_en (cap_shift),
      .bit_in   (sdata_in),
      .word     (cap_word),
      .mism     (cap_mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cs_n     <= 1'b1;
         sclk     <= 1'b0;
         edges_q  <= '0;
         hold_q   <= 1'b0;
         result   <= '0;
         mismatch <= 1'b0;
         valid    <= 1'b0;
      end else begin
         valid <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q    <= ST_RUN;
                  cs_n    <= 1'b0;
                  edges_q <= '0;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (sclk) begin
                     sclk <= 1'b0;
                  end else if (last_edge) begin
                     cs_n     <= 1'b1;
                     st_q     <= ST_HOLD;
                     hold_q   <= 1'b1;
                     result   <= cap_word;
                     mismatch <= cap_mism;
                     valid    <= 1'b1;
                  end else begin
                     sclk    <= 1'b1;
                     edges_q <= edges_q + 1'b1;
                  end
               end
            end
            ST_HOLD: begin
               if (tick) begin
                  if (hold_q) hold_q <= 1'b0;
                  else        st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/adcrd_master_chk.sv
module adcrd_master_chk #(
   parameter int DATA_W       = 12,
   parameter bit MIRROR_CHECK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic [DATA_W-1:0] result,
   input logic              valid,
   input logic              mismatch,
   input logic              busy
);

   a_r8_no_clock_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   a_r6_valid_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $rose(cs_n));

   a_r6_cs_rise_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> valid);

   a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(result));

   a_r10_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> $stable(mismatch));

   a_r7_busy_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> busy);

   a_r1_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && !sclk));

   a_r4_sclk_low_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> !$past(sclk));

   a_r5_no_flag_plain: assert property (@(posedge clk) disable iff (!rst_n)
      !MIRROR_CHECK |-> !mismatch);

endmodule

bind adcrd_master adcrd_master_chk #(.DATA_W(DATA_W), .MIRROR_CHECK(MIRROR_CHECK)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .sclk     (sclk),
   .result   (result),
   .valid    (valid),
   .mismatch (mismatch),
   .busy     (busy)
);

// File: tb/adcrd_master_test.sv
`timescale 1ns/1ps

module adcrd_conv_model #(
   parameter int W = 12
) (
   input  logic         cs_n,
   input  logic         sclk,
   input  logic [W-1:0] word,
   input  logic [W-2:0] flip,
   output logic         dout,
   output int           rises
);
   int   f;
   logic pcs;
   logic psc;

   initial begin
      dout  = 1'b1;
      rises = 0;
      f     = 0;
      pcs   = 1'b1;
      psc   = 1'b0;
   end

   always @(cs_n or sclk) begin
      if (cs_n !== pcs) begin
         if (!cs_n) begin
            f     = 0;
            rises = 0;
         end
         dout = 1'b1;   // undriven line modelled as high
         pcs  = cs_n;
      end else if (sclk !== psc && !cs_n) begin
         if (sclk) begin
            rises++;
         end else begin
            f++;
            if (f == 1)           dout = 1'b0;
            else if (f <= W + 1)  dout = word[W + 1 - f];
            else if (f <= 2 * W)  dout = word[f - W - 1] ^ flip[f - W - 2];
            else                  dout = 1'b0;
         end
      end
      psc = sclk;
   end
endmodule

module adcrd_master_test;
   localparam int DW = 12;
   localparam int VW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic start_nm = 1'b0;
   logic [VW-1:0] div_half = '0;

   logic          cs_n, sclk, valid, mismatch, busy, sdata;
   logic [DW-1:0] result;
   logic          cs_n_nm, sclk_nm, valid_nm, mismatch_nm, busy_nm, sdata_nm;
   logic [DW-1:0] result_nm;

   logic [DW-1:0] m_word = '0;
   logic [DW-2:0] m_flip = '0;
   int            rises, rises_nm;

   int n_chk = 0;
   int n_bad = 0;
   int halfp_bad = 0;
   int run_len = 0;
   logic prev_cs = 1'b1;
   logic prev_sc = 1'b0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   adcrd_master #(.DATA_W(DW), .DIV_W(VW), .MIRROR_CHECK(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .div_half(div_half), .sdata_in(sdata),
      .cs_n(cs_n), .sclk(sclk), .result(result), .valid(valid), .mismatch(mismatch), .busy(busy));

   adcrd_master #(.DATA_W(DW), .DIV_W(VW), .MIRROR_CHECK(1'b0)) uut_nm (
      .clk(clk), .rst_n(rst_n), .start(start_nm), .div_half(div_half), .sdata_in(sdata_nm),
      .cs_n(cs_n_nm), .sclk(sclk_nm), .result(result_nm), .valid(valid_nm),
      .mismatch(mismatch_nm), .busy(busy_nm));

   adcrd_conv_model #(.W(DW)) mdl (.cs_n(cs_n), .sclk(sclk), .word(m_word), .flip(m_flip),
                                    .dout(sdata), .rises(rises));
   adcrd_conv_model #(.W(DW)) mdl_nm (.cs_n(cs_n_nm), .sclk(sclk_nm), .word(m_word), .flip(m_flip),
                                       .dout(sdata_nm), .rises(rises_nm));

   // phase-length monitor for the mirrored instance
   always @(negedge clk) begin
      if (cs_n !== prev_cs || sclk !== prev_sc) begin
         if (prev_cs == 1'b0 && run_len != int'(div_half) + 1) halfp_bad++;
         run_len = 1;
      end else begin
         run_len++;
      end
      prev_cs = cs_n;
      prev_sc = sclk;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic test_reset();
      check("R1 cs_n", cs_n, 1);
      check("R1 sclk", sclk, 0);
      check("R1 busy", busy, 0);
      check("R1 valid", valid, 0);
      check("R1 mismatch", mismatch, 0);
   endtask

   // one mirrored frame; optional second start while busy
   task automatic test_frame(input logic [DW-1:0] w, input logic [DW-2:0] fl,
                             input int dv, input bit retrig);
      int n;
      int bcount;
      m_word = w;
      m_flip = fl;
      div_half = VW'(dv);
      halfp_bad = 0;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      if (retrig) begin
         repeat (7 * (dv + 1)) @(negedge clk);
         start = 1'b1;
         @(negedge clk) start = 1'b0;
      end
      n = 0;
      while (!valid && n < 5000) begin @(negedge clk); n++; end
      check("R6 valid seen", valid, 1);
      check("R3 result word", result, w);
      check("R5 mismatch flag", mismatch, (fl != 0) ? 1 : 0);
      check("R4 edge count", rises, 25);
      check("R2 phase lengths", halfp_bad, 0);
      check("R6 cs_n high with valid", cs_n, 1);
      bcount = 0;
      while (busy && bcount < 5000) begin @(negedge clk); bcount++; if (bcount == 1) check("R6 valid width", valid, 0); end
      check("R7 recovery length", bcount, 2 * (dv + 1));
      repeat (20) @(negedge clk);
      check(retrig ? "R9 no second frame" : "R8 idle select", cs_n, 1);
      check("R10 result held", result, w);
      check("R8 idle clock", sclk, 0);
   endtask

   task automatic test_plain(input logic [DW-1:0] w, input logic [DW-2:0] fl, input int dv);
      int n;
      m_word = w;
      m_flip = fl;
      div_half = VW'(dv);
      @(negedge clk) start_nm = 1'b1;
      @(negedge clk) start_nm = 1'b0;
      n = 0;
      while (!valid_nm && n < 5000) begin @(negedge clk); n++; end
      check("R3 plain result", result_nm, w);
      check("R4 plain edge count", rises_nm, 14);
      check("R5 plain mismatch low", mismatch_nm, 0);
      while (busy_nm && n < 10000) begin @(negedge clk); n++; end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      test_reset();
      test_frame(12'hA5C, '0, 0, 1'b0);
      test_frame(12'hFFF, '0, 2, 1'b0);
      test_frame(12'h001, '0, 1, 1'b0);
      test_frame(12'h800, 11'h001, 0, 1'b0);
      test_frame(12'h3C6, 11'h400, 3, 1'b0);
      test_frame(12'h5A3, '0, 1, 1'b1);
      test_frame(12'h000, '0, 0, 1'b0);
      test_plain(12'hC35, 11'h155, 1);
      test_plain(12'h7FE, '0, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule